// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for every frame that the transmit engine finishes. The engine pushes a raw status byte when a frame ends. The block stores it as a formatted entry in a small first-in first-out store. The host sees the oldest entry on an 8-bit read port, and a write strobe on that port removes the entry.

If the store is full, the new entry is lost. Instead of keeping it, the block marks an overflow flag in the newest entry that is still held. Every push that asks for an interrupt or reports an error produces a one-cycle event for the interrupt unit.

A jabber or underrun report leaves the transmitter halted until the host issues a transmit-reset or global-reset command. Those commands also empty the store. They arrive on a 16-bit command word whose top five bits carry the opcode.

Top module: `tx_cmpl_stack`

## Requirements
- R1: A pushed entry is stored with bit 7 (complete) set to 1 and bits 6..3 copied from `push_stat_i`. In those bits, 6 is interrupt-on-success requested, 5 is jabber, 4 is underrun and 3 is maximum collisions. Bit 2 (overflow) is stored as 0. Bits 1..0 are stored as 0. Input bits 7, 2, 1 and 0 are ignored.
- R2: The store holds 4 entries. `stat_o` shows the oldest entry, so entries leave in the order they were pushed. A push or pop at a clock edge is visible on `stat_o` right after that edge.
- R3: A cycle with `pop_i` high removes the oldest entry. `pop_i` on an empty store has no effect, including when a push happens in the same cycle.
- R4: While the store is empty, `stat_o` reads 0x00, so the complete bit is clear.
- R5: A push into a full store with no pop in the same cycle drops the new entry and sets bit 2 of the newest held entry. The other entries are left unchanged.
- R6: A pop and a push in the same cycle on a non-empty store are both performed and the entry count stays the same. When the store is full this does not set the overflow bit.
- R7: `tx_done_evt_o` is high for exactly the one cycle after a push whose input bits 6..3 are not all zero. This also holds for a dropped push. A push with bits 6..3 all zero raises no event.
- R8: A push with input bit 5 or bit 4 set drives `tx_halt_o` high from the next cycle. It stays high until a reset command.
- R9: `cmd_we_i` with opcode `cmd_i[15:11]` equal to 0x0B (transmit reset) or 0x00 (global reset) empties the store, clears `tx_halt_o` and suppresses the event. It takes priority over a push or pop in the same cycle. Any other opcode has no effect.
- R10: Asserting `rst_ni` low at once empties the store and clears `tx_halt_o` and `tx_done_evt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Transmit engine reports a finished frame |
| push_stat_i | input | 8 | Raw status of the finished frame |
| pop_i | input | 1 | Host write strobe on the status port; removes oldest entry |
| cmd_we_i | input | 1 | Command word valid |
| cmd_i | input | 16 | Command word, opcode in bits 15..11 |
| stat_o | output | 8 | Oldest entry, 0x00 when empty |
| tx_done_evt_o | output | 1 | One-cycle transmit-complete event |
| tx_halt_o | output | 1 | Transmitter held off after a fatal error |

## Verification
The bench fills the store and pushes once more. A design that overwrote the oldest entry, or marked the wrong slot, would show a changed head or a missing overflow bit when the entries are read back.

It pops and pushes together on a full store. A design that treated this as overflow would set bit 2 on the last entry, or would lose one entry.

It also issues a command that is neither reset opcode while halted, and issues a reset in the same cycle as a push. A loose opcode decode would clear the halt. A wrong priority would leave an entry or an event behind.

Finally, it pops an empty store while pushing. A design that let the pop through would corrupt the count and read back 0x00 instead of the new entry.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int STAT_W = 8;
  localparam int OP_W   = 5;

  localparam int BIT_CMPL = 7;
  localparam int BIT_IRQ  = 6;
  localparam int BIT_JAB  = 5;
  localparam int BIT_UND  = 4;
  localparam int BIT_MAXC = 3;
  localparam int BIT_OVF  = 2;

  localparam logic [OP_W-1:0] OP_GLOBAL_RST = 5'h00;
  localparam logic [OP_W-1:0] OP_TX_RST     = 5'h0B;

  typedef logic [STAT_W-1:0] stat_t;

  function automatic stat_t mk_entry(stat_t raw);
    stat_t e;
    e = '0;
    e[BIT_CMPL] = 1'b1;
    e[BIT_IRQ:BIT_MAXC] = raw[BIT_IRQ:BIT_MAXC];
    return e;
  endfunction
endpackage

// File: rtl/txs_ring.sv
module txs_ring #(
  parameter int DEPTH   = 4,
  parameter int W       = 8,
  parameter int OVF_BIT = 2,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PTR_W-1:0] rd_q, wr_q, newest;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     ent [DEPTH];
  logic             empty, full, pop_ok, push_ok, ovf;

  function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign pop_ok  = pop_i && !empty;
  assign push_ok = push_i && (!full || pop_ok);
  // full with no pop: new entry lost, newest slot flagged
  assign ovf     = push_i && full && !pop_ok;
  assign newest  = (wr_q == '0) ? PTR_W'(DEPTH - 1) : wr_q - 1'b1;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
      end else if (!clr_i) begin
        if (push_ok && wr_q == PTR_W'(i)) ent_q <= din_i;
        else if (ovf && newest == PTR_W'(i)) ent_q[OVF_BIT] <= 1'b1;
      end
    end
    assign ent[i] = ent_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_ok)  rd_q <= nxt(rd_q);
      if (push_ok) wr_q <= nxt(wr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = empty ? '0 : ent[rd_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             push_i,
  input  stat_t            raw_i,
  output logic             clr_o,
  output logic             evt_o,
  output logic             halt_o
);
  logic [OP_W-1:0] op;
  logic            evt_q, halt_q, fatal, wants_evt;

  assign op        = cmd_i[CMD_W-1 -: OP_W];
  assign clr_o     = cmd_we_i && (op == OP_TX_RST || op == OP_GLOBAL_RST);
  assign fatal     = raw_i[BIT_JAB] | raw_i[BIT_UND];
  assign wants_evt = |raw_i[BIT_IRQ:BIT_MAXC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= 1'b0;
      halt_q <= 1'b0;
    end else if (clr_o) begin
      evt_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      evt_q <= push_i && wants_evt;
      if (push_i && fatal) halt_q <= 1'b1;
    end
  end

  assign evt_o  = evt_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/tx_cmpl_stack.sv
module tx_cmpl_stack
  import txs_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int CMD_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [STAT_W-1:0] push_stat_i,
  input  logic              pop_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              tx_done_evt_o,
  output logic              tx_halt_o
);
  logic             clr;
  logic [CNT_W-1:0] cnt;
  stat_t            entry;

  assign entry = mk_entry(push_stat_i);

  txs_ctrl #(.CMD_W(CMD_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_we_i(cmd_we_i),
    .cmd_i   (cmd_i),
    .push_i  (push_i),
    .raw_i   (push_stat_i),
    .clr_o   (clr),
    .evt_o   (tx_done_evt_o),
    .halt_o  (tx_halt_o)
  );

  txs_ring #(.DEPTH(DEPTH), .W(STAT_W), .OVF_BIT(BIT_OVF)) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .push_i(push_i),
    .din_i (entry),
    .pop_i (pop_i),
    .head_o(stat_o),
    .cnt_o (cnt)
  );
endmodule

// File: rtl/txs_chk.sv
module txs_chk
  import txs_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int CMD_W  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic [STAT_W-1:0] push_stat_i,
  input logic              pop_i,
  input logic              cmd_we_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              tx_done_evt_o,
  input logic              tx_halt_o,
  input logic [CNT_W-1:0]  cnt_i
);
  logic [OP_W-1:0] op;
  logic            clr_w;
  assign op    = cmd_i[CMD_W-1 -: OP_W];
  assign clr_w = cmd_we_i && (op == OP_TX_RST || op == OP_GLOBAL_RST);

  AST_ENTRY_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[1:0] == 2'b00 && (stat_o == '0 || stat_o[BIT_CMPL])); // R1

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH)); // R2

  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i == '0 |-> stat_o == '0); // R4

  AST_SWAP_KEEPS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && cnt_i != '0 && !clr_w |=> $stable(cnt_i)); // R6

  AST_EVT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_evt_o |-> $past(push_i) && $past(push_stat_i[BIT_IRQ:BIT_MAXC]) != '0); // R7

  AST_HALT_ON_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && (push_stat_i[BIT_JAB] || push_stat_i[BIT_UND]) && !clr_w |=> tx_halt_o); // R8

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_halt_o && !clr_w |=> tx_halt_o); // R8

  AST_CMD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> cnt_i == '0 && !tx_halt_o && !tx_done_evt_o); // R9
endmodule

bind tx_cmpl_stack txs_chk #(.DEPTH(DEPTH), .CMD_W(CMD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_i       (push_i),
  .push_stat_i  (push_stat_i),
  .pop_i        (pop_i),
  .cmd_we_i     (cmd_we_i),
  .cmd_i        (cmd_i),
  .stat_o       (stat_o),
  .tx_done_evt_o(tx_done_evt_o),
  .tx_halt_o    (tx_halt_o),
  .cnt_i        (cnt)
);

// File: tb/tx_cmpl_stack_tb_top.sv
module tx_cmpl_stack_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [7:0]  push_stat_i = '0;
  logic        pop_i = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [15:0] cmd_i = '0;
  logic [7:0]  stat_o;
  logic        tx_done_evt_o, tx_halt_o;

  int checks = 0;
  int errors = 0;

  // scoreboard model
  logic [7:0] exp_q[$];
  logic       exp_evt = 1'b0;
  logic       exp_halt = 1'b0;

  always #2 clk_i = ~clk_i;

  tx_cmpl_stack dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push_i),
    .push_stat_i  (push_stat_i),
    .pop_i        (pop_i),
    .cmd_we_i     (cmd_we_i),
    .cmd_i        (cmd_i),
    .stat_o       (stat_o),
    .tx_done_evt_o(tx_done_evt_o),
    .tx_halt_o    (tx_halt_o)
  );

  task automatic chk(string r, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic monitor(string r);
    chk(r, "stat", stat_o, (exp_q.size() == 0) ? 8'h00 : exp_q[0]);
    chk(r, "evt", {7'b0, tx_done_evt_o}, {7'b0, exp_evt});
    chk(r, "halt", {7'b0, tx_halt_o}, {7'b0, exp_halt});
  endtask

  // driver: applies one cycle of stimulus and updates the expected queue
  task automatic step(logic psh, logic [7:0] raw, logic pp, logic we, logic [15:0] cmd, string r);
    logic clr, pop_ok, full;
    @(negedge clk_i);
    push_i = psh; push_stat_i = raw; pop_i = pp; cmd_we_i = we; cmd_i = cmd;
    clr = we && (cmd[15:11] == 5'h0B || cmd[15:11] == 5'h00);
    if (clr) begin
      exp_q.delete();
      exp_evt = 1'b0;
      exp_halt = 1'b0;
    end else begin
      exp_evt = psh && (raw[6:3] != 4'h0);
      if (psh && (raw[5] || raw[4])) exp_halt = 1'b1;
      full   = (exp_q.size() == 4);
      pop_ok = pp && (exp_q.size() != 0);
      if (pop_ok) void'(exp_q.pop_front());
      if (psh) begin
        if (!full || pop_ok) exp_q.push_back({1'b1, raw[6:3], 3'b000});
        else exp_q[exp_q.size()-1][2] = 1'b1;
      end
    end
    @(posedge clk_i);
    #1;
    monitor(r);
  endtask

  task automatic idle(string r);
    step(1'b0, 8'h00, 1'b0, 1'b0, 16'h0000 | 16'h4800, r);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    monitor("R10");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: formatting, ignored input bits; R7/R8 event and halt
    step(1'b1, 8'hFF, 1'b0, 1'b0, 16'h0, "R1");
    idle("R7");
    step(1'b0, 8'h00, 1'b0, 1'b1, 16'h5800, "R9");
    step(1'b1, 8'h87, 1'b0, 1'b0, 16'h0, "R1");
    step(1'b0, 8'h00, 1'b1, 1'b0, 16'h0, "R3");
    idle("R4");

    // R2: fill and order
    step(1'b1, 8'h00, 1'b0, 1'b0, 16'h0, "R2");
    step(1'b1, 8'h40, 1'b0, 1'b0, 16'h0, "R2");
    step(1'b1, 8'h08, 1'b0, 1'b0, 16'h0, "R2");
    step(1'b1, 8'h00, 1'b0, 1'b0, 16'h0, "R2");
    // R5: overflow push with jabber -> dropped, newest flagged, halt
    step(1'b1, 8'h20, 1'b0, 1'b0, 16'h0, "R5");
    step(1'b0, 8'h00, 1'b0, 1'b1, 16'h4800, "R9");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 1'b0, 16'h0, "R5");
    step(1'b0, 8'h00, 1'b1, 1'b0, 16'h0, "R3");
    step(1'b0, 8'h00, 1'b0, 1'b1, 16'h0000, "R9");

    // R6: simultaneous pop and push on a full store
    step(1'b1, 8'h10, 1'b0, 1'b0, 16'h0, "R8");
    step(1'b0, 8'h00, 1'b0, 1'b1, 16'h5800, "R9");
    for (int i = 0; i < 4; i++) step(1'b1, 8'(i << 3), 1'b0, 1'b0, 16'h0, "R6");
    step(1'b1, 8'h48, 1'b1, 1'b0, 16'h0, "R6");
    step(1'b1, 8'h00, 1'b1, 1'b0, 16'h0, "R6");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 1'b0, 16'h0, "R6");

    // R3: pop on empty with push in the same cycle
    step(1'b1, 8'h18, 1'b1, 1'b0, 16'h0, "R3");
    step(1'b0, 8'h00, 1'b0, 1'b0, 16'h0, "R3");
    // R9: reset command wins over a push
    step(1'b1, 8'h30, 1'b0, 1'b1, 16'h5ABC, "R9");
    idle("R9");

    // R10: asynchronous reset mid-run
    step(1'b1, 8'h70, 1'b0, 1'b0, 16'h0, "R10");
    @(negedge clk_i);
    push_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    exp_q.delete(); exp_evt = 1'b0; exp_halt = 1'b0;
    monitor("R10");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule